// File: doc/BRIEF.md
# Keyboard Scan Interface Unit

This block holds the current image of a keyboard matrix as six 16-bit scan words and tells the processor when that image changes. A key source presents events on a small port. Each event carries a word index, a 16-bit bit pattern and a hold flag. An event is taken only in a cycle where the scan tick is high. On each tick the block first releases all keys and then writes the accepted event into the addressed word.

The hold flag keeps a modifier-plus-key combination visible for one extra tick. If the event on a tick carried the hold flag, the next tick skips its release step once. Whenever the matrix changed on a tick, two status bits are raised. The interrupt request is a level that stays high while any status bit is set. Software reads the words and the status through a 16-bit register port in a 32-byte window. It acknowledges status bits by writing ones to them.

The scan-control and reset registers exist in the window, but writes to them do nothing. Matrix scanning, debounce and repeat timing are not part of this block.

Top module: `kbd_scan_unit`

## Requirements
- R1: After a synchronous active-low reset, all six scan words read zero, the status register reads zero and `irq` is low.
- R2: When `tick` and `ev_valid` are both high and `ev_word` is 0 to 5, the pattern `ev_bits` replaces scan word `ev_word`; it is not ORed in. Scan word k is read at byte offset 2*k (0x00, 0x02, ... 0x0A), with address bit 0 ignored.
- R3: On a tick with no pending hold, every scan word is cleared before the event of that tick, if any, is written.
- R4: An accepted event with `ev_hold` high makes the next tick skip the clear once. That next tick sets the hold again only if its own accepted event carries `ev_hold`.
- R5: A tick counts as a change when any scan word was non-zero before the tick or an event was accepted on it. A change sets status bits 0 (key input detected) and 1 (data complete), giving status value 3. A tick with neither condition leaves the status unchanged.
- R6: The status register is at offset 0x10 and holds three bits, bit 2 meaning lost data (no event in this block sets it). A read returns the bits. A write clears each bit that is 1 in the written data. A change on the same cycle wins over the clear.
- R7: `irq` is high exactly when the status register is non-zero. It changes on the same clock edge as the status register.
- R8: Writes to the scan-control offsets 0x0C and 0x0E and to the reset offset 0x12 change neither the scan words nor the status. Reads of any offset other than a scan word or the status return zero.
- R9: An event with `ev_word` 6 or 7, or one presented while `tick` is low, is ignored. It changes no word, no hold state and no status.
- R10: Read data appears on `rd_data` on the clock edge that samples the read request, and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Scan tick, one cycle wide |
| ev_valid | input | 1 | Key event present |
| ev_word | input | 3 | Scan word index of the event |
| ev_bits | input | 16 | Bit pattern for the addressed word |
| ev_hold | input | 1 | Keep the matrix through the next tick |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset inside the 32-byte window |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check several rules on every cycle:
- a tick with no hold and no event empties the matrix;
- a held tick keeps the words and drops the hold;
- a tick that sees keys raises status value 3;
- a full acknowledge with no tick drops the status and `irq` on the next edge;
- writes to the reset offset disturb nothing.

Only the bench scenarios can show the rest:
- that each word and bit position lands at its own offset, and that the pattern replaces the word;
- that out-of-range and off-tick events are ignored;
- that unmapped reads return zero;
- that partial acknowledges clear only the written bits.

The bench does this by sweeping every word index, valid and invalid, against every single-bit pattern, with a reference model.

// File: rtl/kbd_scan_unit.sv
module kbd_scan_unit #(
  parameter int NWORDS = 6,
  parameter int DW     = 16,
  parameter int AW     = 5,
  parameter int IW     = 3,
  parameter int SW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ev_valid,
  input  logic [IW-1:0] ev_word,
  input  logic [DW-1:0] ev_bits,
  input  logic          ev_hold,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          irq
);

  localparam logic [AW-1:0] STAT_OFS = AW'(16);
  localparam logic [SW-1:0] CHG_BITS = SW'(3);
  localparam int            FW       = NWORDS * DW;

  logic [DW-1:0] word_q [NWORDS];
  logic [FW-1:0] flat;
  logic          hold_q;
  logic [SW-1:0] st_q, st_d;
  logic          any_nz, ev_hit, change, wr_stat, rd_req;
  logic [AW-2:0] rd_idx;

  assign ev_hit  = tick && ev_valid && (int'(ev_word) < NWORDS);
  assign any_nz  = |flat;
  assign change  = tick && (any_nz || ev_hit);
  assign wr_stat = req_valid && req_write && (req_addr == STAT_OFS);
  assign rd_req  = req_valid && !req_write;
  assign rd_idx  = req_addr[AW-1:1];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign flat[g*DW +: DW] = word_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[g] <= '0;
      else if (tick) begin
        if (ev_hit && int'(ev_word) == g)
          word_q[g] <= ev_bits;
        else if (!hold_q)
          word_q[g] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_q <= 1'b0;
    else if (tick)
      hold_q <= ev_hit && ev_hold;
  end

  assign st_d = (st_q & ~(wr_stat ? req_wdata[SW-1:0] : '0)) | (change ? CHG_BITS : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_d;
      if ((|st_d) != irq)
        irq <= |st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_req) begin
      if (req_addr == STAT_OFS)
        rd_data <= DW'(st_q);
      else if (int'(rd_idx) < NWORDS)
        rd_data <= word_q[rd_idx];
      else
        rd_data <= '0;
    end
  end

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !hold_q && !ev_valid |=> flat == '0);

  a_r4_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hold_q && !ev_valid |=> $stable(flat) && !hold_q);

  a_r5_change: assert property (@(posedge clk) disable iff (!rst_n)
    tick && any_nz |=> st_q[1:0] == 2'b11 && irq);

  a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && req_valid && req_write && req_addr == STAT_OFS && (&req_wdata[SW-1:0])
    |=> st_q == '0 && !irq);

  a_r8_rstreg: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && req_valid && req_write && req_addr == AW'(18) |=> $stable(flat) && $stable(st_q));

endmodule

// File: tb/test_kbd_scan_unit.sv
module test_kbd_scan_unit;
  logic clk = 0, rst_n = 0, tick = 0, ev_valid = 0, ev_hold = 0;
  logic [2:0]  ev_word = 0;
  logic [15:0] ev_bits = 0;
  logic req_valid = 0, req_write = 0;
  logic [4:0]  req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [15:0] rd_data;
  logic irq;

  int total = 0, bad = 0;
  logic [15:0] exp_w [6];
  logic        exp_hold;
  logic [2:0]  exp_st;

  always #4 clk = ~clk;

  kbd_scan_unit i_kbd_scan_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_valid(ev_valid), .ev_word(ev_word),
    .ev_bits(ev_bits), .ev_hold(ev_hold), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    v = rd_data;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (a == 5'h10) exp_st &= ~d[2:0];
  endtask

  task automatic do_tick(logic v, logic [2:0] w, logic [15:0] b, logic h);
    logic nz, hit;
    nz = 0;
    foreach (exp_w[k]) if (exp_w[k] != 0) nz = 1;
    hit = v && (w < 6);
    if (!exp_hold) foreach (exp_w[k]) exp_w[k] = 0;
    if (hit) exp_w[w] = b;
    exp_hold = hit && h;
    if (nz || hit) exp_st |= 3'd3;
    @(negedge clk);
    tick = 1; ev_valid = v; ev_word = w; ev_bits = b; ev_hold = h;
    @(posedge clk);
    @(negedge clk);
    tick = 0; ev_valid = 0; ev_hold = 0;
  endtask

  task automatic check_all(string req);
    logic [15:0] v;
    for (int k = 0; k < 6; k++) begin
      rd(5'(2*k), v);
      chk(req, v, exp_w[k]);
    end
    rd(5'h10, v);
    chk(req, v, {13'd0, exp_st});
    chk(req, {15'd0, irq}, {15'd0, exp_st != 0});
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    foreach (exp_w[k]) exp_w[k] = 0;
    exp_hold = 0; exp_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");

    // R2 R3 R5 R9 sweep over every word index and single-bit pattern
    for (int w = 0; w < 8; w++) begin
      for (int b = 0; b < 16; b++) begin
        do_tick(1, 3'(w), 16'(1) << b, 0);
        if (w < 6) begin
          rd(5'(2*w), v);
          chk("R2 word", v, exp_w[w]);
        end
        rd(5'h10, v);
        chk("R5 status", v, {13'd0, exp_st});
        chk("R7 irq", {15'd0, irq}, {15'd0, exp_st != 0});
        wr(5'h10, 16'h0007);
        chk("R7 irq low", {15'd0, irq}, 16'd0);
      end
    end
    check_all("R9 r3_ state");

    // R2 replace, not OR
    do_tick(1, 3'd2, 16'h00F0, 0);
    do_tick(1, 3'd2, 16'h0003, 0);
    check_all("R2 replace");
    do_tick(0, 0, 0, 0);
    check_all("R3 release");
    wr(5'h10, 16'h0007);
    do_tick(0, 0, 0, 0);
    check_all("R5 no change");

    // R4 hold
    do_tick(1, 3'd5, 16'h0800, 1);
    do_tick(1, 3'd1, 16'h0020, 0);
    check_all("R4 held");
    do_tick(0, 0, 0, 0);
    check_all("R4 single skip");
    do_tick(1, 3'd5, 16'h0004, 1);
    do_tick(1, 3'd0, 16'h0001, 1);
    do_tick(0, 0, 0, 0);
    check_all("R4 rehold");
    do_tick(0, 0, 0, 0);
    check_all("R4 final");

    // R9 event without tick
    do_tick(1, 3'd3, 16'h1234, 0);
    wr(5'h10, 16'h0007);
    @(negedge clk);
    ev_valid = 1; ev_word = 3'd3; ev_bits = 16'hFFFF; ev_hold = 1;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0; ev_hold = 0;
    check_all("R9 no tick");
    do_tick(0, 0, 0, 0);
    check_all("R9 no hold");

    // R6 partial clear and R8 ignored writes
    do_tick(1, 3'd4, 16'hA5A5, 0);
    wr(5'h10, 16'h0001);
    check_all("R6 partial");
    wr(5'h0C, 16'hFFFF);
    wr(5'h0E, 16'hFFFF);
    wr(5'h12, 16'hFFFF);
    wr(5'h00, 16'hFFFF);
    check_all("R8 writes");
    for (int a = 12; a < 32; a += 2) begin
      if (a != 16) begin
        rd(5'(a), v);
        chk("R8 unmapped", v, 16'h0000);
      end
    end

    // R10 read data holds
    rd(5'h08, v);
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, 16'hA5A5);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    foreach (exp_w[k]) exp_w[k] = 0;
    exp_hold = 0; exp_st = 0;
    check_all("R1 rereset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule